// File: doc/BRIEF.md
# Debug Run-Control and Instruction Injection Unit

This block is the run-control core of a processor debug unit. It owns the CPU stall line and collects the reasons to stall into one latched halt state. A debug host can ask for a stall directly. A stall also follows from an exception type whose stop enable is set, from an instruction fetch while single-step mode is on, and from a breakpoint signalled by the watchpoint logic. Each cause leaves its own bit in a stop-reason register. A debug-disable bit masks the stall output.

The host can also hand the CPU an instruction through an injection register. If the CPU is already stalled, the instruction is issued on the execute port at once. If the CPU is running, the instruction waits. It then takes the place of the next fetched word, or it is issued when the stall line next rises, whichever happens first. A host reset bit blocks injection and breakpoint evaluation while it is high. When it falls, the block sends a one-cycle reset pulse to the CPU.

The host reaches the registers through a plain address / write-data / write-strobe / read-strobe port with a combinational read path. Register offsets: 0 control, 1 stop enables, 2 stop reason, 3 injection, 4 next-PC.

Top module: `dbg_runctl`

## Requirements
- R1: Control register bit 0 (debug disable) holds `stall_o` low whatever stall is requested. Bit 2 (host stall) raises `stall_o` once the write has taken effect.
- R2: Exception codes 0 to 14 are, in order: reset, bus error, data page fault, instruction page fault, low-priority interrupt, alignment, illegal instruction, high-priority interrupt, data TLB miss, instruction TLB miss, range, syscall, break, trap, reserved. An `exc_valid` pulse with a code whose bit is set in the stop-enable register (offset 1) sets that bit in the reason register (offset 2) and stalls the CPU. A code whose bit is clear has no effect.
- R3: Writing zero to the reason register clears it. Writing a nonzero value leaves it unchanged.
- R4: With control bit 1 (single-step) set, a break exception (code 12) drives `ignore_break_o` high in the same cycle and neither stalls nor sets a reason bit.
- R5: With single-step set, every fetch stalls the CPU and sets reason bit 15.
- R6: `bp_hit` stalls the CPU and sets reason bit 16, unless control bit 3 (host reset) is high. In that case it has no effect.
- R7: An injection write while `stall_o` is high drives `exec_valid_o` for exactly the next cycle, with the written word on `exec_word_o`, and leaves nothing pending.
- R8: An injection write while the CPU runs makes the next fetch return the injected word on `insn_o` with `insn_inj_o` high. The fetch after that returns the fetched word.
- R9: If an injected word is pending when `stall_o` rises, it is issued on `exec_valid_o` in the following cycle and is no longer pending.
- R10: While host reset is high, a pending word is neither issued nor substituted. Clearing the bit gives a one-cycle `cpu_reset_o` pulse.
- R11: A read of the injection register sets `reg_err` and returns no data. A read of a valid register does not set it.
- R12: `exc_pend_o` rises with a stopping exception and is cleared by a host write to the next-PC register (offset 4), which stores the written value.
- R13: A halt caused by an event keeps `stall_o` high until the host writes the control register with bit 4 (release) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Host register offset |
| reg_wdata | input | 32 | Host write data |
| reg_we | input | 1 | Host write strobe |
| reg_re | input | 1 | Host read strobe |
| reg_rdata | output | 32 | Host read data (combinational) |
| reg_err | output | 1 | Access error for the current access |
| exc_valid | input | 1 | Exception occurrence strobe |
| exc_code | input | 4 | Exception type code |
| fetch_valid | input | 1 | CPU instruction fetch strobe |
| fetch_word | input | 32 | Word fetched from memory |
| bp_hit | input | 1 | Breakpoint from the watchpoint logic |
| insn_o | output | 32 | Word delivered to the decoder |
| insn_inj_o | output | 1 | Delivered word came from the host |
| exec_valid_o | output | 1 | Execute the injected word now |
| exec_word_o | output | 32 | Injected word to execute |
| stall_o | output | 1 | CPU stall |
| ignore_break_o | output | 1 | Current break exception is to be ignored |
| exc_pend_o | output | 1 | A stopping exception is pending |
| npc_o | output | 32 | Next-PC value written by the host |
| cpu_reset_o | output | 1 | One-cycle CPU reset pulse |

## Verification
Injection is tried in three stall contexts: already stalled, running with a fetch following, and running with a stall rise following. These separate the immediate path, the fetch-substitution path and the edge-triggered path, and check that each clears the pending word. A fourth pattern keeps host reset high and shows that neither path fires until the bit is cleared. On the stall side, exceptions are sent with and without their enable. A break is sent under single-step, and breakpoints are sent with host reset both low and high. Together these show which sources set which reason bit, and that a halt persists until released.

// File: rtl/dbg_pkg.sv
`timescale 1ns/1ps
package dbg_pkg;
  // host register offsets
  localparam int unsigned OFS_CTRL   = 0;
  localparam int unsigned OFS_STOPEN = 1;
  localparam int unsigned OFS_REASON = 2;
  localparam int unsigned OFS_INJECT = 3;
  localparam int unsigned OFS_NPC    = 4;
  // control register bit positions
  localparam int unsigned CB_DIS     = 0;
  localparam int unsigned CB_STEP    = 1;
  localparam int unsigned CB_HSTALL  = 2;
  localparam int unsigned CB_HRST    = 3;
  localparam int unsigned CB_RELEASE = 4;
endpackage

// File: rtl/dbg_regs.sv
`timescale 1ns/1ps
module dbg_regs #(
  parameter int DW      = 32,
  parameter int AW      = 3,
  parameter int NUM_EXC = 15,
  parameter int RW      = NUM_EXC + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic               reg_we,
  input  logic               reg_re,
  output logic [DW-1:0]      reg_rdata,
  output logic               reg_err,
  input  logic [RW-1:0]      reason,
  output logic               ctrl_dis,
  output logic               ctrl_step,
  output logic               ctrl_hstall,
  output logic               ctrl_hrst,
  output logic [NUM_EXC-1:0] stop_en,
  output logic [DW-1:0]      npc,
  output logic               release_p,
  output logic               reason_clr,
  output logic               inj_wr,
  output logic               npc_wr,
  output logic               cpu_reset_o
);
  import dbg_pkg::*;

  logic hrst_q;
  logic sel_ctrl, sel_stop, sel_reason, sel_inj, sel_npc, sel_ok;

  always_comb begin
    sel_ctrl   = (reg_addr == AW'(OFS_CTRL));
    sel_stop   = (reg_addr == AW'(OFS_STOPEN));
    sel_reason = (reg_addr == AW'(OFS_REASON));
    sel_inj    = (reg_addr == AW'(OFS_INJECT));
    sel_npc    = (reg_addr == AW'(OFS_NPC));
    sel_ok     = sel_ctrl | sel_stop | sel_reason | sel_inj | sel_npc;
  end

  assign release_p  = reg_we & sel_ctrl & reg_wdata[CB_RELEASE];
  assign reason_clr = reg_we & sel_reason & (reg_wdata == '0);
  assign inj_wr     = reg_we & sel_inj;
  assign npc_wr     = reg_we & sel_npc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_dis    <= 1'b0;
      ctrl_step   <= 1'b0;
      ctrl_hstall <= 1'b0;
      ctrl_hrst   <= 1'b0;
      stop_en     <= '0;
      npc         <= '0;
      hrst_q      <= 1'b0;
    end else begin
      hrst_q <= ctrl_hrst;
      if (reg_we && sel_ctrl) begin
        ctrl_dis    <= reg_wdata[CB_DIS];
        ctrl_step   <= reg_wdata[CB_STEP];
        ctrl_hstall <= reg_wdata[CB_HSTALL];
        ctrl_hrst   <= reg_wdata[CB_HRST];
      end
      if (reg_we && sel_stop) stop_en <= reg_wdata[NUM_EXC-1:0];
      if (npc_wr) npc <= reg_wdata;
    end
  end

  // reset pulse on the falling edge of the host reset bit
  assign cpu_reset_o = hrst_q & ~ctrl_hrst;

  always_comb begin
    reg_rdata = '0;
    if (reg_re) begin
      if (sel_ctrl)   reg_rdata = DW'({ctrl_hrst, ctrl_hstall, ctrl_step, ctrl_dis});
      if (sel_stop)   reg_rdata = DW'(stop_en);
      if (sel_reason) reg_rdata = DW'(reason);
      if (sel_npc)    reg_rdata = npc;
    end
    reg_err = ((reg_re | reg_we) & ~sel_ok) | (reg_re & sel_inj);
  end
endmodule

// File: rtl/dbg_stall.sv
`timescale 1ns/1ps
module dbg_stall #(
  parameter int NUM_EXC  = 15,
  parameter int BRK_CODE = 12,
  parameter int CW       = $clog2(NUM_EXC + 1),
  parameter int RW       = NUM_EXC + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_dis,
  input  logic               ctrl_step,
  input  logic               ctrl_hstall,
  input  logic               ctrl_hrst,
  input  logic [NUM_EXC-1:0] stop_en,
  input  logic               exc_valid,
  input  logic [CW-1:0]      exc_code,
  input  logic               fetch_valid,
  input  logic               bp_hit,
  input  logic               release_p,
  input  logic               reason_clr,
  input  logic               npc_wr,
  output logic [RW-1:0]      reason,
  output logic               halted,
  output logic               exc_pend_o,
  output logic               ignore_break_o,
  output logic               stall_o
);
  localparam int STEP_BIT = RW - 2;
  localparam int BP_BIT   = RW - 1;

  // one-hot decode of the exception code, gated by the strobe
  function automatic logic [NUM_EXC-1:0] code_onehot(input logic [CW-1:0] code,
                                                     input logic vld);
    logic [NUM_EXC-1:0] v;
    for (int i = 0; i < NUM_EXC; i++) v[i] = vld && (code == CW'(i));
    return v;
  endfunction

  logic [NUM_EXC-1:0] brk_mask, exc_hits;
  logic [RW-1:0]      new_bits;
  logic               step_stop, bp_stop;

  always_comb begin
    brk_mask       = code_onehot(CW'(BRK_CODE), ctrl_step);
    exc_hits       = code_onehot(exc_code, exc_valid) & stop_en & ~brk_mask;
    step_stop      = fetch_valid & ctrl_step;
    bp_stop        = bp_hit & ~ctrl_hrst;
    new_bits       = '0;
    new_bits[NUM_EXC-1:0] = exc_hits;
    new_bits[STEP_BIT]    = step_stop;
    new_bits[BP_BIT]      = bp_stop;
    ignore_break_o = exc_valid & ctrl_step & (exc_code == CW'(BRK_CODE));
    stall_o        = ~ctrl_dis & (ctrl_hstall | halted);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reason     <= '0;
      halted     <= 1'b0;
      exc_pend_o <= 1'b0;
    end else begin
      reason     <= (reason_clr ? '0 : reason) | new_bits;
      halted     <= (halted & ~release_p) | (|new_bits);
      exc_pend_o <= (exc_pend_o & ~npc_wr) | (|exc_hits);
    end
  end
endmodule

// File: rtl/dbg_inject.sv
`timescale 1ns/1ps
module dbg_inject #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          hrst,
  input  logic          inj_wr,
  input  logic [DW-1:0] inj_data,
  input  logic          fetch_valid,
  input  logic [DW-1:0] fetch_word,
  output logic [DW-1:0] insn_o,
  output logic          insn_inj_o,
  output logic          exec_valid_o,
  output logic [DW-1:0] exec_word_o,
  output logic          pend,
  output logic          stall_rise
);
  logic          stall_q;
  logic [DW-1:0] held;
  logic          issue_now, issue_rise, use_fetch;

  always_comb begin
    stall_rise = stall & ~stall_q;
    issue_now  = inj_wr & stall & ~hrst;
    issue_rise = pend & stall_rise & ~hrst;
    use_fetch  = pend & fetch_valid & ~hrst;
    insn_inj_o = use_fetch;
    insn_o     = use_fetch ? held : fetch_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q      <= 1'b0;
      held         <= '0;
      pend         <= 1'b0;
      exec_valid_o <= 1'b0;
      exec_word_o  <= '0;
    end else begin
      stall_q      <= stall;
      exec_valid_o <= issue_now | issue_rise;
      if (issue_now)       exec_word_o <= inj_data;
      else if (issue_rise) exec_word_o <= held;
      if (inj_wr && !issue_now) begin
        pend <= 1'b1;
        held <= inj_data;
      end else if (use_fetch || issue_rise) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbg_runctl.sv
`timescale 1ns/1ps
module dbg_runctl #(
  parameter int DW       = 32,
  parameter int AW       = 3,
  parameter int NUM_EXC  = 15,
  parameter int BRK_CODE = 12,
  parameter int CW       = $clog2(NUM_EXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_we,
  input  logic          reg_re,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_err,
  input  logic          exc_valid,
  input  logic [CW-1:0] exc_code,
  input  logic          fetch_valid,
  input  logic [DW-1:0] fetch_word,
  input  logic          bp_hit,
  output logic [DW-1:0] insn_o,
  output logic          insn_inj_o,
  output logic          exec_valid_o,
  output logic [DW-1:0] exec_word_o,
  output logic          stall_o,
  output logic          ignore_break_o,
  output logic          exc_pend_o,
  output logic [DW-1:0] npc_o,
  output logic          cpu_reset_o
);
  localparam int RW = NUM_EXC + 2;

  logic               ctrl_dis, ctrl_step, ctrl_hstall, ctrl_hrst;
  logic [NUM_EXC-1:0] stop_en;
  logic [RW-1:0]      reason;
  logic               release_p, reason_clr, inj_wr, npc_wr;
  logic               halted, inj_pend, stall_rise;

  dbg_regs #(.DW(DW), .AW(AW), .NUM_EXC(NUM_EXC), .RW(RW)) u_regs (
    .clk, .rst_n, .reg_addr, .reg_wdata, .reg_we, .reg_re, .reg_rdata, .reg_err,
    .reason, .ctrl_dis, .ctrl_step, .ctrl_hstall, .ctrl_hrst, .stop_en,
    .npc(npc_o), .release_p, .reason_clr, .inj_wr, .npc_wr, .cpu_reset_o
  );

  dbg_stall #(.NUM_EXC(NUM_EXC), .BRK_CODE(BRK_CODE), .CW(CW), .RW(RW)) u_stall (
    .clk, .rst_n, .ctrl_dis, .ctrl_step, .ctrl_hstall, .ctrl_hrst, .stop_en,
    .exc_valid, .exc_code, .fetch_valid, .bp_hit, .release_p, .reason_clr, .npc_wr,
    .reason, .halted, .exc_pend_o, .ignore_break_o, .stall_o
  );

  dbg_inject #(.DW(DW)) u_inj (
    .clk, .rst_n, .stall(stall_o), .hrst(ctrl_hrst), .inj_wr, .inj_data(reg_wdata),
    .fetch_valid, .fetch_word, .insn_o, .insn_inj_o, .exec_valid_o, .exec_word_o,
    .pend(inj_pend), .stall_rise
  );
endmodule

// File: rtl/dbg_runctl_chk.sv
`timescale 1ns/1ps
module dbg_runctl_chk #(
  parameter int NUM_EXC  = 15,
  parameter int BRK_CODE = 12,
  parameter int CW       = 4,
  parameter int RW       = NUM_EXC + 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctrl_dis,
  input logic               ctrl_step,
  input logic               ctrl_hrst,
  input logic               inj_wr,
  input logic               inj_pend,
  input logic               halted,
  input logic               release_p,
  input logic               exc_valid,
  input logic [CW-1:0]      exc_code,
  input logic               fetch_valid,
  input logic [NUM_EXC-1:0] stop_en,
  input logic [RW-1:0]      reason,
  input logic               stall_o,
  input logic               ignore_break_o,
  input logic               exec_valid_o,
  input logic               insn_inj_o,
  input logic               cpu_reset_o
);
  a_r1_disable_masks: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_dis |-> !stall_o);

  a_r2_enabled_exc_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_code < CW'(NUM_EXC) && stop_en[exc_code] &&
     !(ctrl_step && exc_code == CW'(BRK_CODE))) |=> reason[$past(exc_code)] && halted);

  a_r4_break_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && ctrl_step && exc_code == CW'(BRK_CODE)) |-> ignore_break_o);

  a_r5_step_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_step && fetch_valid && !ctrl_dis) |=> stall_o);

  a_r7_immediate_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_wr && stall_o && !ctrl_hrst) |=> (exec_valid_o && !inj_pend));

  a_r8_fetch_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_pend && fetch_valid && !ctrl_hrst && !inj_wr) |=> !inj_pend);

  a_r10_no_substitute_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hrst |-> !insn_inj_o);

  a_r10_reset_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset_o |=> !cpu_reset_o);

  a_r13_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !release_p) |=> halted);
endmodule

bind dbg_runctl dbg_runctl_chk #(.NUM_EXC(NUM_EXC), .BRK_CODE(BRK_CODE), .CW(CW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_dis(ctrl_dis), .ctrl_step(ctrl_step), .ctrl_hrst(ctrl_hrst),
  .inj_wr(inj_wr), .inj_pend(inj_pend), .halted(halted), .release_p(release_p),
  .exc_valid(exc_valid), .exc_code(exc_code), .fetch_valid(fetch_valid), .stop_en(stop_en),
  .reason(reason), .stall_o(stall_o), .ignore_break_o(ignore_break_o),
  .exec_valid_o(exec_valid_o), .insn_inj_o(insn_inj_o), .cpu_reset_o(cpu_reset_o)
);

// File: tb/sim_dbg_runctl.sv
`timescale 1ns/1ps
module sim_dbg_runctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_code = '0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_word = '0;
  logic        bp_hit = 1'b0;
  logic [31:0] insn_o, exec_word_o, npc_o;
  logic        insn_inj_o, exec_valid_o, stall_o, ignore_break_o, exc_pend_o, cpu_reset_o;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  dbg_runctl u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); reg_addr = a; reg_re = 1'b1;
    #1; d = reg_rdata; e = reg_err;
    reg_re = 1'b0;
  endtask

  task automatic exc(input logic [3:0] c);
    @(negedge clk); exc_valid = 1'b1; exc_code = c;
    @(negedge clk); exc_valid = 1'b0;
  endtask

  task automatic fetch(input logic [31:0] w, output logic [31:0] i, output logic inj);
    @(negedge clk); fetch_valid = 1'b1; fetch_word = w;
    #1; i = insn_o; inj = insn_inj_o;
    @(negedge clk); fetch_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    check("reset stall_o", 32'(stall_o), 0);
    check("reset cpu_reset_o", 32'(cpu_reset_o), 0);
    check("reset exec_valid_o", 32'(exec_valid_o), 0);
    rd(3'd2, d, e);
    check("reset reason", d, 0);
  endtask

  task automatic t_disable();   // R1
    wr(3'd0, 32'h5);
    check("R1 disable masks stall", 32'(stall_o), 0);
    wr(3'd0, 32'h4);
    check("R1 host stall", 32'(stall_o), 1);
    wr(3'd0, 32'h0);
    check("R1 host stall off", 32'(stall_o), 0);
  endtask

  task automatic t_exc();       // R2 R12 R13 R3
    logic [31:0] d; logic e;
    wr(3'd1, 32'h1040);
    exc(4'd3);
    check("R2 disabled code no stall", 32'(stall_o), 0);
    exc(4'd6);
    check("R2 enabled code stalls", 32'(stall_o), 1);
    rd(3'd2, d, e);
    check("R2 reason bit", d, 32'h40);
    check("R12 pending set", 32'(exc_pend_o), 1);
    repeat (5) @(negedge clk);
    check("R13 halt persists", 32'(stall_o), 1);
    wr(3'd4, 32'h1234);
    check("R12 npc clears pending", 32'(exc_pend_o), 0);
    rd(3'd4, d, e);
    check("R12 npc stored", d, 32'h1234);
    wr(3'd0, 32'h10);
    check("R13 release", 32'(stall_o), 0);
    wr(3'd2, 32'h5);
    rd(3'd2, d, e);
    check("R3 nonzero write ignored", d, 32'h40);
    wr(3'd2, 32'h0);
    rd(3'd2, d, e);
    check("R3 zero write clears", d, 0);
  endtask

  task automatic t_step();      // R4 R5
    logic [31:0] d, i; logic e, inj;
    wr(3'd0, 32'h2);
    @(negedge clk); exc_valid = 1'b1; exc_code = 4'd12;
    #1; check("R4 ignore_break", 32'(ignore_break_o), 1);
    @(negedge clk); exc_valid = 1'b0;
    check("R4 break no stall", 32'(stall_o), 0);
    rd(3'd2, d, e);
    check("R4 break no reason", d, 0);
    fetch(32'h77, i, inj);
    check("R5 step fetch stalls", 32'(stall_o), 1);
    rd(3'd2, d, e);
    check("R5 step reason", d, 32'h8000);
    wr(3'd0, 32'h10);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_bp();        // R6 R10
    logic [31:0] d; logic e;
    @(negedge clk); bp_hit = 1'b1; @(negedge clk); bp_hit = 1'b0;
    check("R6 bp stalls", 32'(stall_o), 1);
    rd(3'd2, d, e);
    check("R6 bp reason", d, 32'h10000);
    wr(3'd0, 32'h10);
    wr(3'd2, 32'h0);
    wr(3'd0, 32'h8);
    @(negedge clk); bp_hit = 1'b1; @(negedge clk); bp_hit = 1'b0;
    check("R6 bp ignored in host reset", 32'(stall_o), 0);
    rd(3'd2, d, e);
    check("R6 reason untouched in host reset", d, 0);
    wr(3'd0, 32'h0);
    check("R10 reset pulse", 32'(cpu_reset_o), 1);
    @(negedge clk);
    check("R10 reset pulse ends", 32'(cpu_reset_o), 0);
  endtask

  task automatic t_inject();    // R7 R8 R9
    logic [31:0] i; logic inj;
    wr(3'd0, 32'h4);
    wr(3'd3, 32'hA5A50001);
    check("R7 immediate exec", 32'(exec_valid_o), 1);
    check("R7 immediate word", exec_word_o, 32'hA5A50001);
    @(negedge clk);
    check("R7 single pulse", 32'(exec_valid_o), 0);
    wr(3'd0, 32'h0);
    fetch(32'h1111, i, inj);
    check("R7 nothing pending", {i[30:0], inj}, {31'(32'h1111), 1'b0});
    wr(3'd3, 32'hB0B00002);
    check("R8 no exec when running", 32'(exec_valid_o), 0);
    fetch(32'h2222, i, inj);
    check("R8 substituted word", i, 32'hB0B00002);
    check("R8 substituted flag", 32'(inj), 1);
    fetch(32'h3333, i, inj);
    check("R8 next fetch normal", {i[30:0], inj}, {31'(32'h3333), 1'b0});
    wr(3'd3, 32'hC0C00003);
    wr(3'd0, 32'h4);
    check("R9 not yet issued", 32'(exec_valid_o), 0);
    @(negedge clk);
    check("R9 issued on stall rise", 32'(exec_valid_o), 1);
    check("R9 word", exec_word_o, 32'hC0C00003);
    wr(3'd0, 32'h0);
    fetch(32'h4444, i, inj);
    check("R9 pending cleared", 32'(inj), 0);
  endtask

  task automatic t_hrst_inject(); // R10
    logic [31:0] i; logic inj;
    wr(3'd0, 32'hC);
    wr(3'd3, 32'hD0D00004);
    check("R10 no exec in host reset", 32'(exec_valid_o), 0);
    fetch(32'h5555, i, inj);
    check("R10 no substitution in host reset", 32'(inj), 0);
    wr(3'd0, 32'h4);
    check("R10 pulse on fall", 32'(cpu_reset_o), 1);
    wr(3'd0, 32'h0);
    fetch(32'h6666, i, inj);
    check("R10 pending kept through reset", i, 32'hD0D00004);
  endtask

  task automatic t_access();    // R11
    logic [31:0] d; logic e;
    rd(3'd3, d, e);
    check("R11 inject read error", 32'(e), 1);
    rd(3'd1, d, e);
    check("R11 valid read no error", 32'(e), 0);
    check("R11 stop enables readback", d, 32'h1040);
  endtask

  initial begin
    #100000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disable();
    t_exc();
    t_step();
    t_bp();
    t_inject();
    t_hrst_inject();
    t_access();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule